// File: doc/BRIEF.md
# Extended Packed Media ALU

This block runs a small set of 64-bit packed media operations on its own eight-entry register file. Each request names an opcode, a first register and a second operand. The second operand is either another register or a 64-bit value supplied on an input port. A hidden third register takes part in many of the operations. Its index is the first register's index with the lowest bit inverted, so registers pair up as 0/1, 2/3, 4/5 and 6/7.

Depending on the opcode, that partner register receives the result, which leaves both sources intact. In other operations it is the accumulator, or the per-byte condition that decides which bytes a move copies. The multiplying operations take two clocks and all others take one. Every completed operation pulses `done` together with the register index and the value written. The extended operations are off after reset. Software turns them on by writing a configuration value with bit 0 set.

Top module: `media_ext_alu`

## Requirements
- R1: After reset all eight registers read zero, the extended operations are disabled, and `done` and `illegal` are low.
- R2: The partner index is the first register index with bit 0 inverted. When the first register is itself the partner of the intended destination, an implied-destination operation simply overwrites that register.
- R3: Word i is bits 16i+15..16i and byte i is bits 8i+7..8i. Opcode 1 adds and opcode 2 subtracts (first minus second) signed words with saturation to 0x7FFF/0x8000. The result goes to the partner register, and neither source register changes.
- R4: Opcode 3 writes to the first register, per byte, the unsigned average (x+y+1)>>1 of the two operands.
- R5: Opcode 4 adds, per byte, the unsigned absolute difference of the two operands to the partner register's byte, saturating at 0xFF, and writes the sum to the partner register.
- R6: Opcode 5 writes to the first register, per word, the operand word with the larger magnitude. Equal magnitudes keep the first register's word, and 0x8000 counts as the largest magnitude.
- R7: Opcodes 6 and 7 form, per word, the signed 32-bit product plus 0x4000 and keep bits 30..15. Opcode 6 writes the result to the first register and opcode 7 writes it to the partner register.
- R8: Opcode 8 adds the rounded product of R7 to the partner register's word, with 16-bit wraparound, and writes the sum to the partner register.
- R9: Opcodes 9, 10, 11 and 12 copy each byte of the second operand into the first register only where the matching partner byte is, in order: zero, nonzero, negative, or non-negative (signed). Other bytes of the first register keep their value.
- R10: A single-clock operation pulses `done` in the cycle after it is issued. Opcodes 6, 7 and 8 pulse `done` two cycles after issue. A request presented in the cycle after a multiply was issued is ignored.
- R11: Writing `cfg_din` with `cfg_wr` sets the enable from bit 0 only. Opcodes 1 to 12 issued while disabled, and opcodes 13 to 15 at any time, pulse `illegal` one cycle after issue, without `done` and without a register write. Opcode 0 is always allowed.
- R12: Opcode 0 copies the second operand into the first register. The second operand is `mem_val` when `use_mem` is 1 and otherwise the register selected by `rb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_din | input | CFG_W | Configuration value; bit 0 enables the extended operations |
| issue | input | 1 | Request valid |
| opcode | input | 4 | Operation code |
| ra | input | IW | First register index |
| rb | input | IW | Second register index |
| use_mem | input | 1 | Take the second operand from mem_val |
| mem_val | input | 64 | Memory operand value |
| done | output | 1 | One-cycle pulse: an operation completed and wrote a register |
| illegal | output | 1 | One-cycle pulse: request rejected |
| wr_idx | output | IW | Index of the register written |
| wr_data | output | 64 | Value written |

## Verification
On every cycle the assertions check the following. Every pulse has a matching earlier request. `done` and `illegal` never coincide. A multiply request produces no result in the next cycle and a result in the one after. Rejected requests signal `illegal` without `done`. Destination-to-partner operations write to the inverted-bit index, and first-register operations write back to the first index. The arithmetic itself is shown only by the bench's scenarios, which compare results against an independent model. Those scenarios cover saturation at both word limits, byte-level accumulation saturation, magnitude ties and the 0x8000 case, the rounding product of 0x8000 by itself, the four move conditions, the request ignored behind a multiply, and the unchanged state after a rejected request.

// File: rtl/media_ext_alu.sv
module media_ext_alu #(
  parameter int IW    = 3,
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_din,
  input  logic             issue,
  input  logic [3:0]       opcode,
  input  logic [IW-1:0]    ra,
  input  logic [IW-1:0]    rb,
  input  logic             use_mem,
  input  logic [63:0]      mem_val,
  output logic             done,
  output logic             illegal,
  output logic [IW-1:0]    wr_idx,
  output logic [63:0]      wr_data
);
  localparam int NREG = 1 << IW;
  localparam int NW   = 4;
  localparam int NB   = 8;

  logic [63:0]   rf [NREG];
  logic          ext_en;
  logic          busy;
  logic [3:0]    m_op;
  logic [IW-1:0] m_dst;
  logic [63:0]   m_a, m_b, m_c;
  logic [63:0]   res1, mres;
  logic [IW-1:0] dst1;

  wire [IW-1:0] ri     = ra ^ IW'(1);
  wire [63:0]   a      = rf[ra];
  wire [63:0]   b      = use_mem ? mem_val : rf[rb];
  wire [63:0]   c      = rf[ri];
  wire          accept = issue && !busy;
  wire          bad    = (opcode > 4'd12) || (opcode != 4'd0 && !ext_en);
  wire          is_mul = (opcode == 4'd6) || (opcode == 4'd7) || (opcode == 4'd8);

  function automatic logic [15:0] f_sat(input logic [15:0] x, input logic [15:0] y, input logic sub);
    logic signed [16:0] s;
    s = sub ? ($signed({x[15], x}) - $signed({y[15], y}))
            : ($signed({x[15], x}) + $signed({y[15], y}));
    if (s > 17'sd32767)       return 16'h7FFF;
    else if (s < -17'sd32768) return 16'h8000;
    else                      return s[15:0];
  endfunction

  function automatic logic [7:0] f_ave(input logic [7:0] x, input logic [7:0] y);
    logic [8:0] s;
    s = {1'b0, x} + {1'b0, y} + 9'd1;
    return s[8:1];
  endfunction

  function automatic logic [7:0] f_dist(input logic [7:0] acc, input logic [7:0] x, input logic [7:0] y);
    logic [7:0] d;
    logic [8:0] s;
    d = (x > y) ? (x - y) : (y - x);
    s = {1'b0, acc} + {1'b0, d};
    return s[8] ? 8'hFF : s[7:0];
  endfunction

  function automatic logic [15:0] f_mag(input logic [15:0] x, input logic [15:0] y);
    logic [16:0] ax, ay;
    ax = x[15] ? ({1'b0, ~x} + 17'd1) : {1'b0, x};
    ay = y[15] ? ({1'b0, ~y} + 17'd1) : {1'b0, y};
    return (ay > ax) ? y : x;
  endfunction

  function automatic logic [15:0] f_mul(input logic [15:0] x, input logic [15:0] y);
    logic signed [31:0] p;
    p = $signed(x) * $signed(y);
    p = p + 32'sd16384;
    return p[30:15];
  endfunction

  function automatic logic f_cond(input logic [7:0] k, input logic [1:0] sel);
    case (sel)
      2'b01:   return k == 8'h00;
      2'b10:   return k != 8'h00;
      2'b11:   return k[7];
      default: return !k[7];
    endcase
  endfunction

  always_comb begin
    res1 = a;
    dst1 = ra;
    case (opcode)
      4'd0: res1 = b;
      4'd1, 4'd2: begin
        dst1 = ri;
        for (int w = 0; w < NW; w++)
          res1[16*w +: 16] = f_sat(a[16*w +: 16], b[16*w +: 16], opcode == 4'd2);
      end
      4'd3:
        for (int i = 0; i < NB; i++)
          res1[8*i +: 8] = f_ave(a[8*i +: 8], b[8*i +: 8]);
      4'd4: begin
        dst1 = ri;
        for (int i = 0; i < NB; i++)
          res1[8*i +: 8] = f_dist(c[8*i +: 8], a[8*i +: 8], b[8*i +: 8]);
      end
      4'd5:
        for (int w = 0; w < NW; w++)
          res1[16*w +: 16] = f_mag(a[16*w +: 16], b[16*w +: 16]);
      4'd9, 4'd10, 4'd11, 4'd12:
        for (int i = 0; i < NB; i++)
          if (f_cond(c[8*i +: 8], opcode[1:0])) res1[8*i +: 8] = b[8*i +: 8];
      default: ;
    endcase
  end

  always_comb
    for (int w = 0; w < NW; w++)
      mres[16*w +: 16] = (m_op == 4'd8)
        ? m_c[16*w +: 16] + f_mul(m_a[16*w +: 16], m_b[16*w +: 16])
        : f_mul(m_a[16*w +: 16], m_b[16*w +: 16]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) rf[r] <= '0;
      ext_en  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      m_op    <= '0;
      m_dst   <= '0;
      m_a     <= '0;
      m_b     <= '0;
      m_c     <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      if (cfg_wr) ext_en <= cfg_din[0];
      if (busy) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        wr_idx    <= m_dst;
        wr_data   <= mres;
        rf[m_dst] <= mres;
      end else if (accept) begin
        if (bad) begin
          illegal <= 1'b1;
        end else if (is_mul) begin
          busy  <= 1'b1;
          m_op  <= opcode;
          m_dst <= (opcode == 4'd6) ? ra : ri;
          m_a   <= a;
          m_b   <= b;
          m_c   <= c;
        end else begin
          done     <= 1'b1;
          wr_idx   <= dst1;
          wr_data  <= res1;
          rf[dst1] <= res1;
        end
      end
    end
  end
endmodule

// File: rtl/media_ext_alu_chk.sv
module media_ext_alu_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue,
  input logic [3:0]    opcode,
  input logic [IW-1:0] ra,
  input logic          busy,
  input logic          ext_en,
  input logic          done,
  input logic          illegal,
  input logic [IW-1:0] wr_idx
);
  wire take = issue && !busy;

  p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && illegal));

  p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(issue) || $past(issue, 2)));

  p_ill_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(issue));

  p_mul_two_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ext_en && (opcode == 4'd6 || opcode == 4'd7 || opcode == 4'd8))
      |=> (!done && !illegal) ##1 done);

  p_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (opcode > 4'd12 || (opcode != 4'd0 && !ext_en))) |=> (illegal && !done));

  p_partner_dst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ext_en && (opcode == 4'd1 || opcode == 4'd2 || opcode == 4'd4))
      |=> (done && wr_idx == ($past(ra) ^ IW'(1))));

  p_first_dst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ext_en && (opcode == 4'd3 || opcode == 4'd5 || (opcode >= 4'd9 && opcode <= 4'd12)))
      |=> (done && wr_idx == $past(ra)));

  p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (take && opcode == 4'd0) |=> (done && wr_idx == $past(ra)));
endmodule

bind media_ext_alu media_ext_alu_chk #(.IW(IW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .issue  (issue),
  .opcode (opcode),
  .ra     (ra),
  .busy   (busy),
  .ext_en (ext_en),
  .done   (done),
  .illegal(illegal),
  .wr_idx (wr_idx)
);

// File: tb/sim_media_ext_alu.sv
module sim_media_ext_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_din = '0;
  logic        issue = 1'b0;
  logic [3:0]  opcode = '0;
  logic [2:0]  ra = '0, rb = '0;
  logic        use_mem = 1'b0;
  logic [63:0] mem_val = '0;
  logic        done, illegal;
  logic [2:0]  wr_idx;
  logic [63:0] wr_data;

  media_ext_alu u0 (.*);

  always #10 clk = ~clk;

  typedef struct {
    bit          ill;
    logic [2:0]  idx;
    logic [63:0] data;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [63:0] mdl [8];
  bit          en_m = 0;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] ref_op(input logic [3:0] op, input logic [63:0] a,
                                         input logic [63:0] b, input logic [63:0] c);
    logic [63:0] r;
    r = a;
    case (op)
      4'd0: r = b;
      4'd1, 4'd2, 4'd5, 4'd6, 4'd7, 4'd8:
        for (int w = 0; w < 4; w++) begin
          int x, y, s, ax, ay;
          x = $signed(a[16*w +: 16]);
          y = $signed(b[16*w +: 16]);
          if (op == 4'd1 || op == 4'd2) begin
            s = (op == 4'd1) ? x + y : x - y;
            if (s > 32767) s = 32767;
            if (s < -32768) s = -32768;
          end else if (op == 4'd5) begin
            ax = (x < 0) ? -x : x;
            ay = (y < 0) ? -y : y;
            s = (ay > ax) ? y : x;
          end else begin
            s = ((x * y) + 16384) >>> 15;
            if (op == 4'd8) s = s + int'($signed(c[16*w +: 16]));
          end
          r[16*w +: 16] = s[15:0];
        end
      4'd3, 4'd4:
        for (int i = 0; i < 8; i++) begin
          int x, y, s;
          x = a[8*i +: 8];
          y = b[8*i +: 8];
          if (op == 4'd3) s = (x + y + 1) / 2;
          else begin
            s = c[8*i +: 8] + ((x > y) ? x - y : y - x);
            if (s > 255) s = 255;
          end
          r[8*i +: 8] = s[7:0];
        end
      4'd9, 4'd10, 4'd11, 4'd12:
        for (int i = 0; i < 8; i++) begin
          int k;
          bit ok;
          k = $signed(c[8*i +: 8]);
          ok = (op == 4'd9) ? (k == 0) : (op == 4'd10) ? (k != 0) :
               (op == 4'd11) ? (k < 0) : (k >= 0);
          if (ok) r[8*i +: 8] = b[8*i +: 8];
        end
      default: ;
    endcase
    return r;
  endfunction

  task automatic drive(input logic [3:0] op, input int a_i, input int b_i, input bit um,
                       input logic [63:0] mv, input string tag,
                       input bit push_it = 1, input bit chain = 0);
    exp_t        e;
    logic [63:0] src2;
    int          imp;
    bit          mul;
    @(negedge clk);
    issue = 1'b1; opcode = op; ra = a_i[2:0]; rb = b_i[2:0]; use_mem = um; mem_val = mv;
    mul = (op == 4'd6 || op == 4'd7 || op == 4'd8);
    if (push_it) begin
      imp  = a_i ^ 1;
      src2 = um ? mv : mdl[b_i];
      e.tag = tag;
      e.ill = (op > 4'd12) || (op != 4'd0 && !en_m);
      e.cyc = cyc + ((mul && !e.ill) ? 2 : 1);
      e.idx = (op == 4'd1 || op == 4'd2 || op == 4'd4 || op == 4'd7 || op == 4'd8)
              ? 3'(imp) : 3'(a_i);
      e.data = ref_op(op, mdl[a_i], src2, mdl[imp]);
      if (!e.ill) mdl[e.idx] = e.data;
      q.push_back(e);
    end
    @(posedge clk);
    if (mul && push_it && !chain) begin
      @(negedge clk);
      issue = 1'b0;
      @(posedge clk);
    end
    #1 issue = 1'b0;
  endtask

  task automatic set_en(input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_din = v;
    @(posedge clk);
    #1 cfg_wr = 1'b0;
    en_m = v[0];
  endtask

  always @(negedge clk) begin
    if (rst_n && (done || illegal)) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL unexpected pulse done=%0b illegal=%0b idx=%0d data=%h expected none (R10)",
                 done, illegal, wr_idx, wr_data);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (illegal !== e.ill || cyc != e.cyc ||
            (!e.ill && (wr_idx !== e.idx || wr_data !== e.data))) begin
          errors++;
          $display("FAIL %s: got ill=%0b idx=%0d data=%h cyc=%0d expected ill=%0b idx=%0d data=%h cyc=%0d",
                   e.tag, illegal, wr_idx, wr_data, cyc, e.ill, e.idx, e.data, e.cyc);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired (R10) actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) mdl[r] = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (done !== 1'b0 || illegal !== 1'b0) begin
      errors++;
      $display("FAIL R1 outputs after reset: done=%0b illegal=%0b expected 0 0", done, illegal);
    end
    rst_n = 1'b1;

    drive(4'd0, 7, 5, 0, 0, "R1 register zero after reset");
    drive(4'd1, 2, 4, 0, 0, "R11 extended op while disabled");
    drive(4'd0, 6, 3, 0, 0, "R11 partner untouched after rejection");
    set_en(8'hFE);
    drive(4'd5, 0, 0, 0, 0, "R11 only bit0 of config enables");
    set_en(8'h01);
    drive(4'd14, 0, 0, 0, 0, "R11 reserved opcode rejected");

    drive(4'd0, 2, 0, 1, 64'h7000_8000_0005_C000, "R12 load from memory");
    drive(4'd0, 4, 0, 1, 64'h2000_8000_FFFD_C000, "R12 load from memory");
    drive(4'd1, 2, 4, 0, 0, "R3 saturating add to partner");
    drive(4'd0, 7, 2, 0, 0, "R3 first source unchanged");
    drive(4'd0, 7, 4, 0, 0, "R12 second source unchanged via register path");
    drive(4'd2, 2, 0, 1, 64'h9000_7FFF_0001_4001, "R3 saturating subtract");
    drive(4'd1, 3, 2, 0, 0, "R2 partner is first source");

    drive(4'd0, 5, 0, 1, 64'hFF00_0102_8081_FFFE, "R12 load");
    drive(4'd3, 5, 0, 1, 64'hFF01_0103_7F80_0001, "R4 byte average");
    drive(4'd0, 4, 0, 1, 64'h0010_FF00_2030_0180, "R12 load");
    drive(4'd4, 4, 0, 1, 64'hF000_00FF_3020_8001, "R5 distance accumulate");
    drive(4'd4, 4, 0, 1, 64'h0F80_7F01_FF00_1234, "R5 distance saturation");

    drive(4'd0, 6, 0, 1, 64'h8000_0005_FFFB_1234, "R12 load");
    drive(4'd5, 6, 0, 1, 64'h7FFF_FFFB_0005_EDCC, "R6 magnitude ties and 0x8000");
    drive(4'd5, 6, 0, 1, 64'h8000_0006_8001_0001, "R6 magnitude second wins");
    drive(4'd0, 0, 0, 1, 64'h8000_4000_FFFF_7FFF, "R12 load");
    drive(4'd6, 6, 0, 0, 0, "R7 multiply high to first register");
    drive(4'd0, 0, 0, 1, 64'h8000_C000_0003_7FFF, "R12 load");
    drive(4'd7, 0, 6, 0, 0, "R7 multiply high to partner");
    drive(4'd8, 0, 6, 0, 0, "R8 multiply accumulate");
    drive(4'd8, 0, 0, 1, 64'h7FFF_7FFF_7FFF_7FFF, "R8 accumulate wraparound");

    drive(4'd0, 1, 0, 1, 64'h0080_7FFF_0001_8000, "R12 load");
    drive(4'd0, 0, 0, 1, 64'hA1A2_A3A4_A5A6_A7A8, "R12 load");
    drive(4'd9, 0, 0, 1, 64'h1111_1111_1111_1111, "R9 move if zero");
    drive(4'd10, 0, 0, 1, 64'h2222_2222_2222_2222, "R9 move if nonzero");
    drive(4'd0, 0, 0, 1, 64'hA1A2_A3A4_A5A6_A7A8, "R12 load");
    drive(4'd11, 0, 0, 1, 64'h3333_3333_3333_3333, "R9 move if negative");
    drive(4'd12, 0, 0, 1, 64'h4444_4444_4444_4444, "R9 move if non-negative");

    drive(4'd6, 2, 4, 0, 0, "R10 multiply two-cycle latency", 1, 1);
    drive(4'd0, 3, 0, 1, 64'hDEAD_BEEF_DEAD_BEEF, "R10 ignored", 0);
    drive(4'd0, 7, 3, 0, 0, "R10 request behind multiply was ignored");

    set_en(8'h00);
    drive(4'd9, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R11 disabled again");
    drive(4'd0, 7, 0, 0, 0, "R11 target unchanged after rejection");

    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing results: pending=%0d expected 0", q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule